// File: doc/BRIEF.md
# Interrupt Cell and Mask Controller

This block keeps a vector of interrupt-pending cells and a small pool of mask registers for a memory-side system controller. The controller has several ports. I/O agents raise cells through a set vector. Privileged requesters on the ports can read, load or OR-set the cells. They can also read or replace mask registers, read how masks are routed, and acknowledge the highest-priority pending cell. Each mask register in the pool is either unused or routed to one port by static configuration inputs. A port's interrupt line is the OR-reduction of its routed mask ANDed with the cell vector.

Requests use a valid/ready handshake. Each request carries the requesting port, a 3-bit operation code, a target port and a 32-bit data word. Each accepted request produces exactly one response one clock later. An acknowledge returns the number of the lowest-numbered cell that is both pending and enabled for the requester, and clears that cell in the same operation. When no such cell exists, the acknowledge returns a distinct empty response. The block keeps no notion of an interrupt in service, so priority is resolved only when an acknowledge arrives.

Top module: `irq_cell_ctrl`

## Requirements
- R1: After reset all cells and all mask registers are 0, every `irq_out` bit is low, `rsp_valid` is low, and `req_ready` is high from the first clock after reset.
- R2: Operation 1 loads all cells from `req_data`. Operation 0 returns the whole cell vector in `rsp_data`.
- R3: Operation 2 ORs `req_data` into the cells. It never clears a cell, and a zero operand leaves the cells unchanged.
- R4: A 1 on `io_set[i]` sets cell i whatever the masks hold. When it coincides with an acknowledge that clears cell i, the cell stays set.
- R5: Operation 4 replaces all bits of the requester's own mask, and operation 3 reads that mask back. A requester with no mask reads 0, and its writes change nothing.
- R6: Operation 5 replaces all bits of the mask routed to port `req_target`. It has no effect if that port has no mask.
- R7: `irq_out[p]` is high exactly when the mask routed to port p and the cells share a 1 bit. The line follows a mask or cell change with no added delay, and a port with no mask stays low.
- R8: Operation 7 returns, in `rsp_data[4:0]` with the upper bits 0, the lowest-numbered cell that is pending and enabled for the requester. It clears that cell.
- R9: Operation 7 with no pending enabled cell for the requester sets `rsp_empty` with `rsp_data` 0 and leaves the cells unchanged.
- R10: Operation 6 returns one byte per mask register, with register m in bits [8m+7:8m]. Bit 7 of the byte is the enable and bits 2:0 are the routed port.
- R11: If two enabled mask registers name the same port, `cfg_err` is high and that port uses the lower-indexed register. Otherwise `cfg_err` is low.
- R12: `rsp_valid` is high in the cycle after each accepted request and low after every cycle with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mask_en | input | 4 | Per mask register: routed to a port when 1 |
| cfg_mask_port | input | 12 | Routed port of mask m in bits [3m+2:3m] |
| io_set | input | 32 | Per-cell set pulses from I/O agents |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_port | input | 3 | Requesting port |
| req_op | input | 3 | Operation code (0..7) |
| req_target | input | 3 | Target port for operation 5 |
| req_data | input | 32 | Operand |
| rsp_valid | output | 1 | Response valid |
| rsp_empty | output | 1 | Acknowledge found no enabled pending cell |
| rsp_data | output | 32 | Response word |
| irq_out | output | 8 | Interrupt line per port |
| cfg_err | output | 1 | Two enabled masks route to one port |

## Verification
The acknowledge is swept over all 32 cell positions. In each case every cell from the swept position upward is pending, which shows whether the lowest index is taken and exactly one cell is cleared. Masked and empty cases separate masking from pending state. Walking-one loads and reads of the cells show whether any bit position is mis-wired. A sweep of the mask routing across all eight ports shows whether each mask reaches only its own line. A duplicate route separates the lowest-index rule from other ways of breaking the tie. A same-cycle I/O set and acknowledge on one cell shows whether the set takes precedence.

// File: rtl/irq_cell_pkg.sv
package irq_cell_pkg;
   typedef enum logic [2:0] {
      OP_RD_CELLS  = 3'd0,
      OP_WR_CELLS  = 3'd1,
      OP_SET_CELLS = 3'd2,
      OP_RD_OWN    = 3'd3,
      OP_WR_OWN    = 3'd4,
      OP_WR_PORT   = 3'd5,
      OP_RD_ROUTE  = 3'd6,
      OP_ACK       = 3'd7
   } irq_op_e;
endpackage

// File: rtl/irq_port_map.sv
module irq_port_map #(
   parameter int NUM_PORTS = 8,
   parameter int NUM_MASKS = 4,
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int MSEL_W = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1
) (
   input  logic [NUM_MASKS-1:0]        cfg_en,
   input  logic [NUM_MASKS*PORT_W-1:0] cfg_port,
   output logic [NUM_PORTS-1:0]        has_mask,
   output logic [NUM_PORTS*MSEL_W-1:0] sel_flat,
   output logic                        cfg_err
);
   logic [NUM_PORTS-1:0] dup;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic              hit;
      logic              twice;
      logic [MSEL_W-1:0] idx;
      always_comb begin
         hit   = 1'b0;
         twice = 1'b0;
         idx   = '0;
         // descending scan: the last match written is the lowest index
         for (int m = NUM_MASKS - 1; m >= 0; m--) begin
            if (cfg_en[m] && (cfg_port[m*PORT_W +: PORT_W] == PORT_W'(p))) begin
               if (hit) twice = 1'b1;
               hit = 1'b1;
               idx = MSEL_W'(m);
            end
         end
      end
      assign has_mask[p]                  = hit;
      assign sel_flat[p*MSEL_W +: MSEL_W] = idx;
      assign dup[p]                       = twice;
   end

   assign cfg_err = |dup;
endmodule

// File: rtl/irq_lowest_sel.sv
module irq_lowest_sel #(
   parameter int W = 32,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_cell_array.sv
module irq_cell_array #(
   parameter int NUM_CELLS = 32,
   localparam int CELL_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_en,
   input  logic [NUM_CELLS-1:0] load_val,
   input  logic                 or_en,
   input  logic [NUM_CELLS-1:0] or_val,
   input  logic                 clr_en,
   input  logic [CELL_W-1:0]    clr_idx,
   input  logic [NUM_CELLS-1:0] io_set,
   output logic [NUM_CELLS-1:0] cells_q
);
   for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
      logic nxt;
      always_comb begin
         nxt = cells_q[c];
         if (load_en) nxt = load_val[c];
         if (or_en && or_val[c]) nxt = 1'b1;
         if (clr_en && (clr_idx == CELL_W'(c))) nxt = 1'b0;
         if (io_set[c]) nxt = 1'b1;   // set has the last word
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cells_q[c] <= 1'b0;
         else        cells_q[c] <= nxt;
      end
   end
endmodule

// File: rtl/irq_cell_ctrl.sv
module irq_cell_ctrl
   import irq_cell_pkg::*;
#(
   parameter int NUM_CELLS = 32,
   parameter int NUM_MASKS = 4,
   parameter int NUM_PORTS = 8,
   parameter int DATA_W    = 32,
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int MSEL_W = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1,
   localparam int CELL_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
   localparam int FLD_W  = DATA_W / NUM_MASKS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_MASKS-1:0]        cfg_mask_en,
   input  logic [NUM_MASKS*PORT_W-1:0] cfg_mask_port,
   input  logic [NUM_CELLS-1:0]        io_set,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [PORT_W-1:0]           req_port,
   input  logic [2:0]                  req_op,
   input  logic [PORT_W-1:0]           req_target,
   input  logic [DATA_W-1:0]           req_data,
   output logic                        rsp_valid,
   output logic                        rsp_empty,
   output logic [DATA_W-1:0]           rsp_data,
   output logic [NUM_PORTS-1:0]        irq_out,
   output logic                        cfg_err
);
   // elaboration-time parameter checks
   if (NUM_CELLS != DATA_W) begin : g_bad_width
      $error("NUM_CELLS must equal DATA_W");
   end
   if (FLD_W < PORT_W + 1 || FLD_W < 2) begin : g_bad_field
      $error("route field too narrow for NUM_MASKS/NUM_PORTS");
   end
   if (NUM_MASKS < 1 || NUM_PORTS < 1) begin : g_bad_count
      $error("need at least one mask and one port");
   end

   logic [NUM_PORTS-1:0]        has_mask;
   logic [NUM_PORTS*MSEL_W-1:0] sel_flat;
   logic [NUM_CELLS-1:0]        cells_q;
   logic [NUM_CELLS-1:0]        mask_q   [NUM_MASKS];
   logic [NUM_CELLS-1:0]        eff_mask [NUM_PORTS];
   logic [MSEL_W-1:0]           sel_of   [NUM_PORTS];
   logic                        rdy_q;

   irq_port_map #(.NUM_PORTS(NUM_PORTS), .NUM_MASKS(NUM_MASKS)) u_map (
      .cfg_en   (cfg_mask_en),
      .cfg_port (cfg_mask_port),
      .has_mask (has_mask),
      .sel_flat (sel_flat),
      .cfg_err  (cfg_err)
   );

   // per-port effective mask and interrupt line
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_line
      assign sel_of[p]   = sel_flat[p*MSEL_W +: MSEL_W];
      assign eff_mask[p] = has_mask[p] ? mask_q[sel_of[p]] : '0;
      assign irq_out[p]  = |(eff_mask[p] & cells_q);
   end

   irq_op_e op;
   logic    fire;
   assign op        = irq_op_e'(req_op);
   assign req_ready = rdy_q;
   assign fire      = req_valid & rdy_q;

   logic [NUM_CELLS-1:0] req_mask;
   logic                 ack_found;
   logic [CELL_W-1:0]    ack_idx;
   assign req_mask = eff_mask[req_port];

   irq_lowest_sel #(.W(NUM_CELLS)) u_prio (
      .vec   (cells_q & req_mask),
      .found (ack_found),
      .idx   (ack_idx)
   );

   logic is_ack;
   assign is_ack = fire && (op == OP_ACK);

   irq_cell_array #(.NUM_CELLS(NUM_CELLS)) u_cells (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (fire && (op == OP_WR_CELLS)),
      .load_val (req_data[NUM_CELLS-1:0]),
      .or_en    (fire && (op == OP_SET_CELLS)),
      .or_val   (req_data[NUM_CELLS-1:0]),
      .clr_en   (is_ack && ack_found),
      .clr_idx  (ack_idx),
      .io_set   (io_set),
      .cells_q  (cells_q)
   );

   // mask pool: whole-register replacement only
   logic [NUM_MASKS-1:0] mwr_en;
   always_comb begin
      for (int m = 0; m < NUM_MASKS; m++) begin
         mwr_en[m] = (fire && (op == OP_WR_OWN) && has_mask[req_port]
                      && (sel_of[req_port] == MSEL_W'(m)))
                   | (fire && (op == OP_WR_PORT) && has_mask[req_target]
                      && (sel_of[req_target] == MSEL_W'(m)));
      end
   end

   for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         mask_q[m] <= '0;
         else if (mwr_en[m]) mask_q[m] <= req_data[NUM_CELLS-1:0];
      end
   end

   // route read word
   logic [DATA_W-1:0] route_word;
   always_comb begin
      route_word = '0;
      for (int m = 0; m < NUM_MASKS; m++) begin
         route_word[m*FLD_W + FLD_W - 1]    = cfg_mask_en[m];
         route_word[m*FLD_W +: PORT_W]      = cfg_mask_port[m*PORT_W +: PORT_W];
      end
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      unique case (op)
         OP_RD_CELLS: rd_mux = DATA_W'(cells_q);
         OP_RD_OWN:   rd_mux = DATA_W'(req_mask);
         OP_RD_ROUTE: rd_mux = route_word;
         OP_ACK:      rd_mux = ack_found ? DATA_W'(ack_idx) : '0;
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q     <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_empty <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rdy_q     <= 1'b1;
         rsp_valid <= fire;
         rsp_empty <= is_ack && !ack_found;
         rsp_data  <= fire ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/irq_cell_chk.sv
module irq_cell_chk #(
   parameter int NUM_CELLS = 32,
   parameter int NUM_MASKS = 4,
   parameter int NUM_PORTS = 8,
   parameter int DATA_W    = 32,
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int CELL_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_MASKS-1:0]        cfg_mask_en,
   input logic [NUM_MASKS*PORT_W-1:0] cfg_mask_port,
   input logic [NUM_CELLS-1:0]        io_set,
   input logic                        req_valid,
   input logic                        req_ready,
   input logic [2:0]                  req_op,
   input logic                        rsp_valid,
   input logic                        rsp_empty,
   input logic [DATA_W-1:0]           rsp_data,
   input logic [NUM_PORTS-1:0]        irq_out,
   input logic                        cfg_err,
   input logic [NUM_CELLS-1:0]        cells_q
);
   logic [NUM_PORTS-1:0] routed;
   logic                 dup_seen;
   always_comb begin
      routed   = '0;
      dup_seen = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         int cnt;
         cnt = 0;
         for (int m = 0; m < NUM_MASKS; m++)
            if (cfg_mask_en[m] && cfg_mask_port[m*PORT_W +: PORT_W] == PORT_W'(p)) cnt++;
         routed[p] = (cnt > 0);
         if (cnt > 1) dup_seen = 1'b1;
      end
   end

   logic                 live_q;
   logic [NUM_CELLS-1:0] io_q;
   logic                 ack_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         io_q   <= '0;
         ack_q  <= 1'b0;
      end else begin
         live_q <= 1'b1;
         io_q   <= io_set;
         ack_q  <= req_valid && req_ready && (req_op == 3'd7);
      end
   end

   // R12
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);
   // R12
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);
   // R9
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_empty |-> (rsp_valid && rsp_data == '0));
   // R7
   unrouted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~routed) == '0);
   // R11
   cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err == dup_seen);
   // R4
   io_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> ((cells_q & io_q) == io_q));
   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && ack_q && rsp_valid && !rsp_empty && !io_q[rsp_data[CELL_W-1:0]])
      |-> !cells_q[rsp_data[CELL_W-1:0]]);
endmodule

bind irq_cell_ctrl irq_cell_chk #(
   .NUM_CELLS(NUM_CELLS), .NUM_MASKS(NUM_MASKS),
   .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_mask_en(cfg_mask_en), .cfg_mask_port(cfg_mask_port),
   .io_set(io_set), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
   .rsp_valid(rsp_valid), .rsp_empty(rsp_empty), .rsp_data(rsp_data),
   .irq_out(irq_out), .cfg_err(cfg_err), .cells_q(cells_q)
);

// File: tb/irq_cell_ctrl_tb_top.sv
module irq_cell_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] io_set = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_port = '0;
   logic [2:0]  req_op = '0;
   logic [2:0]  req_target = '0;
   logic [31:0] req_data = '0;
   logic        rsp_valid, rsp_empty, cfg_err;
   logic [31:0] rsp_data;
   logic [7:0]  irq_out;
   logic [3:0]  c_en = 4'b0111;
   logic [2:0]  c_port [4];
   logic [11:0] cfg_port_flat;

   assign cfg_port_flat = {c_port[3], c_port[2], c_port[1], c_port[0]};

   irq_cell_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mask_en(c_en), .cfg_mask_port(cfg_port_flat),
      .io_set(io_set), .req_valid(req_valid), .req_ready(req_ready),
      .req_port(req_port), .req_op(req_op), .req_target(req_target),
      .req_data(req_data), .rsp_valid(rsp_valid), .rsp_empty(rsp_empty),
      .rsp_data(rsp_data), .irq_out(irq_out), .cfg_err(cfg_err)
   );

   always #10 clk = ~clk;

   int nvec = 0;
   int nbad = 0;
   logic [31:0] m_cells = '0;
   logic [31:0] m_mask [4] = '{default: '0};

   function automatic int owner(input int p);
      for (int m = 0; m < 4; m++)
         if (c_en[m] && c_port[m] == 3'(p)) return m;
      return -1;
   endfunction

   function automatic logic [7:0] exp_irq();
      logic [7:0] r = '0;
      for (int p = 0; p < 8; p++) begin
         int o = owner(p);
         if (o >= 0) r[p] = |(m_mask[o] & m_cells);
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one request; drive at negedge, check response at the following negedge
   task automatic req(input string tag, input int port, input int op,
                      input logic [31:0] data, input int tgt, input logic [31:0] io);
      logic [31:0] e_data = '0;
      logic        e_empty = 1'b0;
      int          o;
      req_valid = 1'b1; req_port = 3'(port); req_op = 3'(op);
      req_data = data; req_target = 3'(tgt); io_set = io;
      @(posedge clk);
      o = owner(port);
      case (op)
         0: e_data = m_cells;
         1: m_cells = data;
         2: m_cells = m_cells | data;
         3: e_data = (o >= 0) ? m_mask[o] : '0;
         4: if (o >= 0) m_mask[o] = data;
         5: begin o = owner(tgt); if (o >= 0) m_mask[o] = data; end
         6: for (int m = 0; m < 4; m++) e_data[m*8 +: 8] = {c_en[m], 4'b0, c_port[m]};
         default: begin
            logic [31:0] v = m_cells & ((o >= 0) ? m_mask[o] : 32'h0);
            if (v == 0) e_empty = 1'b1;
            else begin
               for (int i = 31; i >= 0; i--) if (v[i]) e_data = i;
               m_cells[e_data[4:0]] = 1'b0;
            end
         end
      endcase
      m_cells = m_cells | io;
      @(negedge clk);
      req_valid = 1'b0; io_set = '0;
      chk({tag, " R12 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
      chk({tag, " rsp_data"}, rsp_data, e_data);
      chk({tag, " rsp_empty"}, {31'b0, rsp_empty}, {31'b0, e_empty});
      chk({tag, " R7 irq_out"}, {24'b0, irq_out}, {24'b0, exp_irq()});
   endtask

   initial begin
      #(20 * 200000);
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      c_port[0] = 3'd1; c_port[1] = 3'd3; c_port[2] = 3'd5; c_port[3] = 3'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq_out", {24'b0, irq_out}, 32'd0);
      chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
      chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
      chk("R11 no dup", {31'b0, cfg_err}, 32'd0);
      req("R1 cells", 0, 0, 0, 0, 0);
      req("R1 mask", 1, 3, 0, 0, 0);

      // R2 walking ones and fixed patterns
      for (int i = 0; i < 32; i++) begin
         req("R2 wr", 4, 1, 32'h1 << i, 0, 0);
         req("R2 rd", 4, 0, 0, 0, 0);
      end
      req("R2 wr", 4, 1, 32'hA5A5_5A5A, 0, 0);
      req("R2 rd", 4, 0, 0, 0, 0);

      // R3 OR-set
      req("R3 wr", 0, 1, 32'h0000_00F0, 0, 0);
      req("R3 set", 0, 2, 32'h0F00_000F, 0, 0);
      req("R3 rd", 0, 0, 0, 0, 0);
      req("R3 set0", 0, 2, 32'h0, 0, 0);
      req("R3 rd", 0, 0, 0, 0, 0);

      // R5 own mask
      req("R5 wr own", 1, 4, 32'h0000_FFFF, 0, 0);
      req("R5 rd own", 1, 3, 0, 0, 0);
      req("R5 wr unrouted", 2, 4, 32'hFFFF_FFFF, 0, 0);
      req("R5 rd unrouted", 2, 3, 0, 0, 0);

      // R6 write another port's mask
      req("R6 wr port3", 0, 5, 32'hFFFF_0000, 3, 0);
      req("R6 rd port3", 3, 3, 0, 0, 0);
      req("R6 wr port7 none", 0, 5, 32'h1234_5678, 7, 0);
      req("R6 rd port7", 7, 3, 0, 0, 0);

      // R7 immediate line on mask raise
      req("R7 cells", 0, 1, 32'h0000_0100, 0, 0);
      req("R7 mask5 raise", 0, 5, 32'h0000_0100, 5, 0);
      chk("R7 line5", {31'b0, irq_out[5]}, 32'd1);
      // route sweep over all ports for mask0
      req("R7 fill", 0, 1, 32'hFFFF_FFFF, 0, 0);
      for (int p = 0; p < 8; p++) begin
         c_port[0] = 3'(p);
         #1;
         chk("R7 route sweep", {24'b0, irq_out}, {24'b0, exp_irq()});
         @(negedge clk);
      end
      c_port[0] = 3'd1;
      #1;

      // R10 route word
      req("R10 route", 6, 6, 0, 0, 0);

      // R8 acknowledge sweep
      req("R8 mask all", 1, 4, 32'hFFFF_FFFF, 0, 0);
      for (int i = 0; i < 32; i++) begin
         req("R8 load", 1, 1, ~((32'h1 << i) - 32'h1), 0, 0);
         req("R8 ack", 1, 7, 0, 0, 0);
         req("R8 rd", 1, 0, 0, 0, 0);
      end
      req("R8 mask hi", 1, 4, 32'hFFFF_0000, 0, 0);
      req("R8 fill", 1, 1, 32'hFFFF_FFFF, 0, 0);
      req("R8 ack masked", 1, 7, 0, 0, 0);

      // R9 empty response
      req("R9 load", 1, 1, 32'h0000_FFFF, 0, 0);
      req("R9 ack none", 1, 7, 0, 0, 0);
      req("R9 ack unrouted", 2, 7, 0, 0, 0);
      req("R9 rd", 1, 0, 0, 0, 0);

      // R4 io set wins over acknowledge clear; ignores masks
      req("R4 mask all", 1, 4, 32'hFFFF_FFFF, 0, 0);
      req("R4 load", 1, 1, 32'h0000_0010, 0, 0);
      req("R4 ack+io", 1, 7, 0, 0, 32'h0000_0010);
      req("R4 rd", 1, 0, 0, 0, 0);
      req("R4 io unmasked", 6, 0, 0, 0, 32'h8000_0000);
      req("R4 rd", 6, 0, 0, 0, 0);

      // R11 duplicate routing
      c_en = 4'b1111; c_port[3] = 3'd1;
      #1;
      chk("R11 cfg_err", {31'b0, cfg_err}, 32'd1);
      @(negedge clk);
      req("R11 rd own", 1, 3, 0, 0, 0);
      req("R11 wr own", 1, 4, 32'h0000_0003, 0, 0);
      req("R11 rd own", 1, 3, 0, 0, 0);
      c_port[3] = 3'd0;
      req("R11 mask3 untouched", 0, 3, 0, 0, 0);
      chk("R11 cfg_err clear", {31'b0, cfg_err}, 32'd0);

      // R12 idle cycle
      @(negedge clk);
      chk("R12 idle", {31'b0, rsp_valid}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule